// File: doc/BRIEF.md
# SPI Byte Memory Slave Front End

This block sits between a four-wire SPI bus and an 8192-byte synchronous memory macro. It accepts SPI mode 0 and mode 3 transfers and decodes the one command byte that opens each select period. It collects a two-byte byte address and then streams data into or out of the array. Every received data byte is written on the same bus cycle that completes it, so the host never has to poll for a ready state. A burst continues through an address counter that steps once per byte and wraps at the top of the array.

The bus pins are oversampled in the block's own clock domain, so the shift engine, the command sequencer and the memory port all run from one clock. The write-enable latch, the status byte and the address lock belong to a separate protection unit. This block raises set and clear pulses for that latch and presents status reads and writes to the unit. Before it writes a byte, it reads the unit's write-enable state and lock answer. A pause input freezes the shift engine partway through a byte and releases the output.

Top module: `spi_bytemem_slave`

## Requirements
- R1: SI is captured on rising SCK edges and SO advances on falling SCK edges, MSB first. A bus that idles SCK low (mode 0) and a bus that idles it high (mode 3) both transfer correctly.
- R2: The first byte after CS_n goes low is the command. Any further byte in the same select period is never decoded as a command.
- R3: READ (0x03) and WRITE (0x02) take a high address byte and then a low address byte. Bits 7:5 of the high byte are ignored, and bits 4:0 of that byte with the low byte form the 13-bit address.
- R4: Each WRITE data byte reaches the memory port as a one-cycle write strobe, carrying that byte and the current address, in the clock cycles right after its eighth bit is captured.
- R5: The address steps by one after every data byte, read or written, whether or not the write was allowed, and wraps from 0x1FFF to 0x0000.
- R6: The SO output enable is low at all times except while read data or status data is being shifted out, and always low while CS_n is high.
- R7: While HOLD_n is low, SCK edges are ignored and the SO enable is low. When HOLD_n returns high, the transfer resumes at the bit where it stopped.
- R8: CS_n high returns the block to waiting for a command. A byte cut short by CS_n rising causes no write.
- R9: WREN (0x06) pulses the latch-set output and WRDI (0x04) pulses the latch-clear output. Any command outside the six listed ones is ignored until CS_n rises.
- R10: A WRITE data byte is dropped with no indication when the write-enable state is low or when the protection unit marks its address as locked.
- R11: RDSR (0x05) shifts out the status byte supplied by the protection unit, repeated for every further byte. WRSR (0x01) hands exactly one following byte to the unit with a one-cycle strobe.
- R12: When CS_n rises after a select period in which a WRITE data byte or a WRSR byte was completed, the latch-clear output pulses once. A period that completed no such byte leaves the latch alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; must run well above the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | SPI serial data out (valid when so_oe is high) |
| so_oe | output | 1 | Output enable for the SO pad driver |
| mem_addr | output | 13 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one cycle per byte |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_addr |
| addr_locked | input | 1 | Protection unit: mem_addr lies in a locked region |
| wen_state | input | 1 | Protection unit: write-enable latch state |
| stat_rdata | input | 8 | Protection unit: status byte to return |
| stat_wdata | output | 8 | Status byte offered to the protection unit |
| stat_we | output | 1 | Strobe for stat_wdata |
| wen_set | output | 1 | Pulse that sets the write-enable latch |
| wen_clr | output | 1 | Pulse that clears the write-enable latch |

## Verification
On every cycle, the assertions check that the SO enable stays low once a deselect or a pause has been seen through the synchronizer. They also check that write and status strobes last one cycle, and that a memory write happens only with the latch set and the address unlocked. They check that the address steps after each write, and that the latch set and clear pulses never coincide. Only the bench scenarios can show the data itself: that bytes arrive at the right addresses in both SPI modes, that reads return what was written across the wrap point, and that aborted, paused and trailing bytes are handled as required. The same is true of latch state after each kind of select period.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_WR_DATA,
    PH_RD_DATA,
    PH_STAT_RD,
    PH_STAT_WR,
    PH_SKIP
  } phase_e;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_mem_shifter.sv
module spi_mem_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         rise,
  input  logic         fall,
  input  logic         si,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         rx_done,
  output logic [W-1:0] rx_byte,
  output logic         tx_bit
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  rx_q, rx_d;
  logic [W-1:0]  tx_q, tx_d;
  logic          upd_en;

  always_comb begin
    cnt_d = cnt_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    if (clear) begin
      cnt_d = '0;
      rx_d  = '0;
    end else begin
      if (rise) begin
        rx_d  = {rx_q[W-2:0], si};
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      // first falling edge of a byte keeps the freshly loaded MSB
      if (fall && (cnt_q != '0)) tx_d = {tx_q[W-2:0], 1'b0};
    end
    if (load) tx_d = load_data;
  end

  assign upd_en = clear | rise | fall | load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
    end
  end

  assign rx_done = rise && !clear && (cnt_q == LAST);
  assign rx_byte = {rx_q[W-2:0], si};
  assign tx_bit  = tx_q[W-1];

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              wen_state,
  input  logic              addr_locked,
  input  logic [DATA_W-1:0] stat_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] stat_wdata,
  output logic              stat_we,
  output logic              wen_set,
  output logic              wen_clr,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  output logic              drive_phase
);

  localparam int HI_W     = ADDR_W - DATA_W;
  localparam int PF_DEPTH = RD_LAT + 1;

  phase_e              phase_q, phase_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                is_rd_q, is_rd_d;
  logic                wrote_q, wrote_d;
  logic                we_q, we_d;
  logic                inc_q, inc_d;
  logic [DATA_W-1:0]   wdata_q, wdata_d;
  logic [PF_DEPTH-1:0] pf_q, pf_d;
  logic                set_q, set_d;
  logic                clr_q, clr_d;
  logic                swe_q, swe_d;
  logic [DATA_W-1:0]   swd_q, swd_d;

  always_comb begin
    phase_d = phase_q;
    addr_d  = addr_q;
    is_rd_d = is_rd_q;
    wrote_d = wrote_q;
    we_d    = 1'b0;
    inc_d   = 1'b0;
    wdata_d = wdata_q;
    pf_d    = {pf_q[PF_DEPTH-2:0], 1'b0};
    set_d   = 1'b0;
    clr_d   = 1'b0;
    swe_d   = 1'b0;
    swd_d   = swd_q;
    tx_load = 1'b0;
    tx_data = mem_rdata;

    // deferred step after a write byte, so the strobe sees its own address
    if (inc_q) addr_d = addr_q + 1'b1;

    // read data returns RD_LAT cycles after the address settles
    if (pf_q[PF_DEPTH-1]) tx_load = 1'b1;

    if (clear) begin
      phase_d = PH_CMD;
      is_rd_d = 1'b0;
      wrote_d = 1'b0;
      pf_d    = '0;
      clr_d   = wrote_q;
    end else if (rx_done) begin
      unique case (phase_q)
        PH_CMD: begin
          unique case (rx_byte)
            OP_WREN:  begin set_d = 1'b1; phase_d = PH_SKIP; end
            OP_WRDI:  begin clr_d = 1'b1; phase_d = PH_SKIP; end
            OP_RDSR:  begin
              tx_load = 1'b1;
              tx_data = stat_rdata;
              phase_d = PH_STAT_RD;
            end
            OP_WRSR:  phase_d = PH_STAT_WR;
            OP_READ:  begin is_rd_d = 1'b1; phase_d = PH_ADDR_HI; end
            OP_WRITE: begin is_rd_d = 1'b0; phase_d = PH_ADDR_HI; end
            default:  phase_d = PH_SKIP;
          endcase
        end
        PH_ADDR_HI: begin
          addr_d[ADDR_W-1:DATA_W] = rx_byte[HI_W-1:0];
          phase_d = PH_ADDR_LO;
        end
        PH_ADDR_LO: begin
          addr_d[DATA_W-1:0] = rx_byte;
          if (is_rd_q) begin
            pf_d[0] = 1'b1;
            phase_d = PH_RD_DATA;
          end else begin
            phase_d = PH_WR_DATA;
          end
        end
        PH_WR_DATA: begin
          wrote_d = 1'b1;
          we_d    = wen_state & ~addr_locked;
          wdata_d = rx_byte;
          inc_d   = 1'b1;
        end
        PH_RD_DATA: begin
          addr_d  = addr_q + 1'b1;
          pf_d[0] = 1'b1;
        end
        PH_STAT_RD: begin
          tx_load = 1'b1;
          tx_data = stat_rdata;
        end
        PH_STAT_WR: begin
          swe_d   = 1'b1;
          swd_d   = rx_byte;
          wrote_d = 1'b1;
          phase_d = PH_SKIP;
        end
        PH_SKIP: ;
        default: phase_d = PH_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      addr_q  <= '0;
      is_rd_q <= 1'b0;
      wrote_q <= 1'b0;
      we_q    <= 1'b0;
      inc_q   <= 1'b0;
      wdata_q <= '0;
      pf_q    <= '0;
      set_q   <= 1'b0;
      clr_q   <= 1'b0;
      swe_q   <= 1'b0;
      swd_q   <= '0;
    end else begin
      phase_q <= phase_d;
      addr_q  <= addr_d;
      is_rd_q <= is_rd_d;
      wrote_q <= wrote_d;
      we_q    <= we_d;
      inc_q   <= inc_d;
      wdata_q <= wdata_d;
      pf_q    <= pf_d;
      set_q   <= set_d;
      clr_q   <= clr_d;
      swe_q   <= swe_d;
      swd_q   <= swd_d;
    end
  end

  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign mem_we      = we_q;
  assign stat_wdata  = swd_q;
  assign stat_we     = swe_q;
  assign wen_set     = set_q;
  assign wen_clr     = clr_q;
  assign drive_phase = (phase_q == PH_RD_DATA) || (phase_q == PH_STAT_RD);

endmodule

// File: rtl/spi_bytemem_slave.sv
module spi_bytemem_slave #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RD_LAT      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              addr_locked,
  input  logic              wen_state,
  input  logic [DATA_W-1:0] stat_rdata,
  output logic [DATA_W-1:0] stat_wdata,
  output logic              stat_we,
  output logic              wen_set,
  output logic              wen_clr
);

  localparam int NPIN = 4;
  localparam logic [NPIN-1:0] PIN_IDLE = 4'b1100; // hold_n, cs_n, sck, si

  logic [1:0]      rst_pipe;
  logic            rst_int_n;
  logic [NPIN-1:0] pins_s;
  logic            hold_s, cs_s, sck_s, si_s;
  logic            sck_d;
  logic            active, clear, rise, fall;
  logic            rx_done, tx_bit, tx_load, drive_phase;
  logic [DATA_W-1:0] rx_byte, tx_data;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  spi_mem_sync #(
    .WIDTH  (NPIN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    ({hold_n, cs_n, sck, si}),
    .q    (pins_s)
  );

  assign {hold_s, cs_s, sck_s, si_s} = pins_s;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sck_d <= 1'b0;
    else            sck_d <= sck_s;
  end

  // a pause masks both edges and freezes deselect handling
  assign active = ~cs_s & hold_s;
  assign clear  = cs_s & hold_s;
  assign rise   = active & sck_s & ~sck_d;
  assign fall   = active & ~sck_s & sck_d;

  spi_mem_shifter #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear    (clear),
    .rise     (rise),
    .fall     (fall),
    .si       (si_s),
    .load     (tx_load),
    .load_data(tx_data),
    .rx_done  (rx_done),
    .rx_byte  (rx_byte),
    .tx_bit   (tx_bit)
  );

  spi_mem_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .RD_LAT(RD_LAT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear      (clear),
    .rx_done    (rx_done),
    .rx_byte    (rx_byte),
    .wen_state  (wen_state),
    .addr_locked(addr_locked),
    .stat_rdata (stat_rdata),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .stat_wdata (stat_wdata),
    .stat_we    (stat_we),
    .wen_set    (wen_set),
    .wen_clr    (wen_clr),
    .tx_load    (tx_load),
    .tx_data    (tx_data),
    .drive_phase(drive_phase)
  );

  assign so_oe = drive_phase & active;
  assign so    = so_oe & tx_bit;

endmodule

// File: rtl/spi_bytemem_checker.sv
module spi_bytemem_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              hold_n,
  input logic              so_oe,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wen_state,
  input logic              addr_locked,
  input logic              stat_we,
  input logic              wen_set,
  input logic              wen_clr
);

  AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe); // R6

  AST_OE_OFF_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !$past(hold_n) && !$past(hold_n, 2)) |-> !so_oe); // R7

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R4

  AST_WE_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wen_state && !addr_locked)); // R10

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R5

  AST_STAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> !stat_we); // R11

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wen_set && wen_clr)); // R9

endmodule

bind spi_bytemem_slave spi_bytemem_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .hold_n     (hold_n),
  .so_oe      (so_oe),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .wen_state  (wen_state),
  .addr_locked(addr_locked),
  .stat_we    (stat_we),
  .wen_set    (wen_set),
  .wen_clr    (wen_clr)
);

// File: tb/spi_bytemem_slave_test.sv
module spi_bytemem_slave_test;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, mem_we, stat_we, wen_set, wen_clr;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, stat_wdata;
  logic [7:0]  stat_rdata = 8'h8C;
  logic        prot_en = 1'b0;
  logic        wen_state, addr_locked;

  spi_bytemem_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .addr_locked(addr_locked),
    .wen_state(wen_state), .stat_rdata(stat_rdata), .stat_wdata(stat_wdata),
    .stat_we(stat_we), .wen_set(wen_set), .wen_clr(wen_clr)
  );

  // memory and protection-unit models
  logic [7:0] mdl [int];
  logic [7:0] shadow [int];
  always @(posedge clk) begin
    mem_rdata <= mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 8'h00;
    if (mem_we) mdl[int'(mem_addr)] = mem_wdata;
  end
  assign addr_locked = prot_en && (mem_addr >= 13'h1800);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wen_state <= 1'b0;
    else if (wen_set) wen_state <= 1'b1;
    else if (wen_clr) wen_state <= 1'b0;
  end

  int checks = 0, failures = 0;
  bit exp_wel = 1'b0;
  bit finished = 1'b0;

  logic [20:0] exp_wr[$];
  string       wr_tag[$];
  logic [7:0]  exp_rd[$];
  string       rd_tag[$];
  logic [7:0]  rx_q[$];
  logic [7:0]  exp_sr[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as results appear
  logic [7:0]  m_got, m_exp;
  logic [20:0] m_wexp;
  string       m_tag;
  always @(negedge clk) begin
    if (rx_q.size() != 0) begin
      m_got = rx_q.pop_front();
      m_exp = exp_rd.pop_front();
      m_tag = rd_tag.pop_front();
      chk(m_got == m_exp, m_tag, 32'(m_got), 32'(m_exp));
    end
    if (rst_n && mem_we) begin
      if (exp_wr.size() == 0) chk(1'b0, "R10 unexpected write", 32'({mem_addr, mem_wdata}), 32'h0);
      else begin
        m_wexp = exp_wr.pop_front();
        m_tag  = wr_tag.pop_front();
        chk({mem_addr, mem_wdata} == m_wexp, m_tag, 32'({mem_addr, mem_wdata}), 32'(m_wexp));
      end
    end
    if (rst_n && stat_we) begin
      if (exp_sr.size() == 0) chk(1'b0, "R11 unexpected status write", 32'(stat_wdata), 32'h0);
      else begin
        m_exp = exp_sr.pop_front();
        chk(stat_wdata == m_exp, "R11 status write", 32'(stat_wdata), 32'(m_exp));
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sck = 1'b0;
    si  = b;
    wait_clk(HALF);
    r   = so;
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
  endtask

  task automatic start(input bit m3);
    sck = m3;
    wait_clk(2);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic stop(input bit m3);
    if (!m3) sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(3 * HALF);
  endtask

  task automatic raw(input bit m3, input int n, input logic [63:0] bytes);
    logic [7:0] r;
    start(m3);
    for (int i = 0; i < n; i++) xbyte(bytes[63-8*i -: 8], r);
    stop(m3);
  endtask

  task automatic wr(input bit m3, input logic [15:0] a, input int n, input logic [31:0] d, input string tag);
    logic [7:0] r;
    start(m3);
    xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      logic [12:0] ea;
      logic [7:0]  b;
      ea = a[12:0] + 13'(i);
      b  = d[31-8*i -: 8];
      if (exp_wel && !(prot_en && ea >= 13'h1800)) begin
        exp_wr.push_back({ea, b});
        wr_tag.push_back(tag);
        shadow[int'(ea)] = b;
      end
      xbyte(b, r);
    end
    stop(m3);
    exp_wel = 1'b0;
  endtask

  function automatic logic [7:0] peek(input logic [12:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
  endfunction

  task automatic rd(input bit m3, input logic [15:0] a, input int n, input string tag);
    logic [7:0] r;
    start(m3);
    xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      exp_rd.push_back(peek(a[12:0] + 13'(i)));
      rd_tag.push_back(tag);
      xbyte(8'h00, r);
      rx_q.push_back(r);
    end
    stop(m3);
  endtask

  task automatic wren(input bit m3);
    raw(m3, 1, {8'h06, 56'h0});
    exp_wel = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(8);

    // R6: quiet after reset
    chk(so_oe == 1'b0, "R6 reset so_oe", 32'(so_oe), 0);
    chk(mem_we == 1'b0, "R4 reset mem_we", 32'(mem_we), 0);
    chk(wen_state == 1'b0, "R9 reset latch", 32'(wen_state), 0);

    // R9 set pulse, R3 don't-care bits, R4 burst write, R12 clear on deselect
    wren(1'b0);
    chk(wen_state == 1'b1, "R9 WREN sets latch", 32'(wen_state), 1);
    wr(1'b0, 16'hE010, 3, 32'hA53C7E00, "R3 R4 write burst mode0");
    chk(wen_state == 1'b0, "R12 latch cleared after WRITE", 32'(wen_state), 0);
    chk(so_oe == 1'b0, "R6 so_oe idle", 32'(so_oe), 0);

    // R1 mode 3 read, R5 increment
    rd(1'b1, 16'h0010, 3, "R1 R5 read mode3");

    // R10 latch clear drops write
    wr(1'b1, 16'h0020, 1, 32'h11000000, "R10 no latch");
    rd(1'b0, 16'h0020, 1, "R10 readback unwritten");

    // R10 locked address drops write
    wren(1'b0);
    prot_en = 1'b1;
    wr(1'b0, 16'h17FF, 2, 32'h22330000, "R10 lock boundary");
    prot_en = 1'b0;
    rd(1'b1, 16'h17FF, 2, "R10 readback lock boundary");

    // R5 wrap
    wren(1'b1);
    wr(1'b1, 16'h1FFF, 2, 32'h44550000, "R5 wrap write");
    rd(1'b0, 16'h1FFE, 3, "R5 wrap read");

    // R11 status read and write
    start(1'b0);
    xbyte(8'h05, r);
    for (int i = 0; i < 2; i++) begin
      exp_rd.push_back(8'h8C); rd_tag.push_back("R11 status read");
      xbyte(8'h00, r); rx_q.push_back(r);
    end
    stop(1'b0);
    wren(1'b0);
    exp_sr.push_back(8'h0C);
    raw(1'b0, 3, {8'h01, 8'h0C, 8'h0D, 40'h0});
    chk(wen_state == 1'b0, "R12 latch cleared after WRSR", 32'(wen_state), 0);

    // R9 clear pulse and unknown command
    wren(1'b0);
    raw(1'b1, 1, {8'h04, 56'h0});
    chk(wen_state == 1'b0, "R9 WRDI clears latch", 32'(wen_state), 0);
    wren(1'b0);
    raw(1'b0, 5, {8'h9F, 8'h02, 8'h00, 8'h30, 8'h77, 24'h0});
    chk(wen_state == 1'b1, "R9 unknown command ignored", 32'(wen_state), 1);

    // R2 bytes after a command never decode as another command
    raw(1'b1, 5, {8'h06, 8'h02, 8'h00, 8'h40, 8'h66, 24'h0});
    chk(wen_state == 1'b1, "R2 trailing bytes ignored", 32'(wen_state), 1);

    // R8 abort mid byte
    start(1'b0);
    xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h50, r);
    for (int i = 7; i >= 4; i--) bit_x(1'b1, r[i]);
    stop(1'b0);
    chk(wen_state == 1'b1, "R8 R12 abort keeps latch", 32'(wen_state), 1);
    wr(1'b0, 16'h0050, 1, 32'h99000000, "R8 write after abort");
    rd(1'b1, 16'h0050, 1, "R8 readback");

    // R7 pause during read
    start(1'b0);
    xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h10, r);
    for (int i = 7; i >= 4; i--) bit_x(1'b0, r[i]);
    sck = 1'b0; wait_clk(HALF);
    hold_n = 1'b0; wait_clk(HALF);
    chk(so_oe == 1'b0, "R7 so_oe off in pause", 32'(so_oe), 0);
    for (int k = 0; k < 3; k++) begin
      si = ~si; sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    chk(so_oe == 1'b0, "R7 so_oe off after toggles", 32'(so_oe), 0);
    hold_n = 1'b1; wait_clk(HALF);
    for (int i = 3; i >= 0; i--) bit_x(1'b0, r[i]);
    stop(1'b0);
    chk(r == peek(13'h0010), "R7 read resumes", 32'(r), 32'(peek(13'h0010)));

    // R7 pause during write
    wren(1'b1);
    start(1'b0);
    xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h60, r);
    exp_wr.push_back({13'h0060, 8'h5A}); wr_tag.push_back("R7 write resumes");
    shadow[32'h60] = 8'h5A;
    for (int i = 7; i >= 4; i--) bit_x(8'h5A >> i, r[0]);
    sck = 1'b0; wait_clk(HALF);
    hold_n = 1'b0; wait_clk(HALF);
    for (int k = 0; k < 3; k++) begin
      si = 1'b1; sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    hold_n = 1'b1; wait_clk(HALF);
    for (int i = 3; i >= 0; i--) bit_x(8'h5A >> i, r[0]);
    stop(1'b0);
    exp_wel = 1'b0;
    rd(1'b0, 16'h0060, 1, "R7 write readback");

    wait_clk(20);
    chk(exp_wr.size() == 0, "R4 pending writes", 32'(exp_wr.size()), 0);
    chk(exp_rd.size() == 0, "R1 pending reads", 32'(exp_rd.size()), 0);
    chk(exp_sr.size() == 0, "R11 pending status writes", 32'(exp_sr.size()), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule